// File: doc/BRIEF.md
# Multiplexer-Carry Ripple Adder

This block adds two unsigned operands of a configurable width together with a single carry bit and returns the total one bit wider than the operands. It is built as a straight chain of identical one-bit cells, least significant bit first. Each cell passes its carry to the next cell up.

Each cell first forms a half-sum bit as the exclusive-OR of its two operand bits. That half-sum is combined with the arriving carry to make the sum bit. The outgoing carry comes from a two-input selector steered by the half-sum, not from a majority gate. When the two operand bits differ, the selector forwards the arriving carry. When they agree, it forwards operand bit a, which then equals operand bit b. This arrangement maps directly onto the dedicated carry-select chains found in programmable logic.

The block is purely combinational and has no clock or reset. A plain two-operand adder ties `carry_in` to 0.

Top module: `mxc_ripple_adder`

## Requirements
- R1: Each bit position's sum output equals the parity (exclusive-OR) of its operand a bit, its operand b bit and its incoming carry.
- R2: Each bit position's outgoing carry equals its incoming carry when its two operand bits differ, and equals its operand a bit when they are equal. For all eight input combinations, the pair {carry, sum} equals a + b + carry-in.
- R3: The result is WIDTH+1 bits wide (17 bits by default). Bits WIDTH-1..0 hold the sum and bit WIDTH holds the final carry-out.
- R4: The carry chain runs from bit 0 upward. The result equals op_a + op_b + carry_in, computed at WIDTH+1 bits, for every operand value.
- R5: A carry entering at bit 0 propagates the full length of the chain. With op_a all ones, op_b zero and carry_in 1, the result is 2^WIDTH.
- R6: With carry_in 0 and operand bit pairs (a,b) of (0,1), (1,0), (0,1) from bit 0 upward (op_a=2, op_b=5), sum bits 2..0 are all 1 and no carry leaves bit 2 (result 7).
- R7: A single-bit instance with both operand bits 1 and carry_in 1 gives sum 1 and carry 1 (result 2'b11).
- R8: The result follows the inputs combinationally, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First unsigned operand; also the carry source at positions whose bits agree |
| op_b | input | WIDTH | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0; tie to 0 for plain addition |
| result | output | WIDTH+1 | Sum bits in WIDTH-1..0, final carry in bit WIDTH |

## Verification
The bench drives a one-bit instance through all eight cell input combinations. This catches a selector with its data inputs swapped: such a selector would forward operand a when the bits differ and lose or invent a carry. On the 16-bit instance, a carry is forced through all sixteen stages and all-ones operands are added with a carry-in. These cases expose a broken link in the chain or a dropped top carry bit, which would show up as a wrong high bit or a result truncated to sixteen bits. The two worked bit-pattern examples, alternating bit patterns and seeded random operands cover the general arithmetic.

// File: rtl/mxc_pkg.sv
package mxc_pkg;
  // One-bit cell outputs grouped together.
  typedef struct packed {
    logic carry;
    logic sum;
  } mxc_bit_t;

  localparam int unsigned MXC_DEFAULT_WIDTH = 16;
endpackage

// File: rtl/mxc_carry_mux.sv
module mxc_carry_mux (
  input  logic sel,
  input  logic in_one,
  input  logic in_zero,
  output logic out
);
  // Two-input selector matching a carry-chain select element.
  always_comb begin
    out = sel ? in_one : in_zero;
  end
endmodule

// File: rtl/mxc_cell.sv
module mxc_cell
  import mxc_pkg::*;
(
  input  logic bit_a,
  input  logic bit_b,
  input  logic c_in,
  output logic s_out,
  output logic c_out
);
  logic     half_sum;
  mxc_bit_t res;

  always_comb begin
    half_sum  = bit_a ^ bit_b;
    res.sum   = half_sum ^ c_in;
  end

  // Carry: forward c_in when the bits differ, bit_a when they agree.
  mxc_carry_mux u_cmux (
    .sel    (half_sum),
    .in_one (c_in),
    .in_zero(bit_a),
    .out    (res.carry)
  );

  assign s_out = res.sum;
  assign c_out = res.carry;

  // R2: the arithmetic total of the cell matches the selector-built pair
  always_comb begin
    p_cell_total_r2: assert ({c_out, s_out} == (2'(bit_a) + 2'(bit_b) + 2'(c_in)))
      else $error("cell total mismatch");
  end

  // R2: when both operand bits agree, the carry equals that common value
  always_comb begin
    if (bit_a == bit_b) begin
      p_agree_carry_r2: assert (c_out == bit_b)
        else $error("agreeing bits did not set carry");
    end
  end

  // R1: sum is set exactly when an odd number of inputs are high
  always_comb begin
    p_sum_parity_r1: assert (s_out == ($countones({bit_a, bit_b, c_in}) % 2 == 1))
      else $error("cell sum parity mismatch");
  end
endmodule

// File: rtl/mxc_column.sv
module mxc_column #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] col_a,
  input  logic [WIDTH-1:0] col_b,
  input  logic             col_cin,
  output logic [WIDTH-1:0] col_sum,
  output logic             col_cout
);
  localparam int unsigned LINKS = WIDTH + 1;

  logic [LINKS-1:0] link;

  assign link[0] = col_cin;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    mxc_cell u_cell (
      .bit_a(col_a[g]),
      .bit_b(col_b[g]),
      .c_in (link[g]),
      .s_out(col_sum[g]),
      .c_out(link[g+1])
    );

    // R4: a carry leaves bit g only if two or more of its inputs are high
    always_comb begin
      p_link_majority_r4: assert (link[g+1] ==
          ($countones({col_a[g], col_b[g], link[g]}) >= 2))
        else $error("carry link %0d wrong", g);
    end
  end

  assign col_cout = link[WIDTH];
endmodule

// File: rtl/mxc_ripple_adder.sv
module mxc_ripple_adder #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH:0]   result
);
  localparam int unsigned RES_W = WIDTH + 1;

  logic [WIDTH-1:0] sum_bits;
  logic             top_carry;

  mxc_column #(.WIDTH(WIDTH)) u_column (
    .col_a   (op_a),
    .col_b   (op_b),
    .col_cin (carry_in),
    .col_sum (sum_bits),
    .col_cout(top_carry)
  );

  assign result = {top_carry, sum_bits};

  // R4: whole result equals the arithmetic sum at full width
  always_comb begin
    p_total_match_r4: assert (result ==
        ({1'b0, op_a} + {1'b0, op_b} + RES_W'(carry_in)))
      else $error("adder total mismatch");
  end

  // R3: the top bit is set whenever both operands are all ones
  always_comb begin
    if ((&op_a) && (&op_b)) begin
      p_top_carry_r3: assert (result[WIDTH])
        else $error("top carry missing");
    end
  end

  // R5: all-ones plus zero plus carry-in yields exactly 2^WIDTH
  always_comb begin
    if ((&op_a) && (op_b == '0) && carry_in) begin
      p_full_ripple_r5: assert (result == (RES_W'(1) << WIDTH))
        else $error("full ripple failed");
    end
  end
endmodule

// File: tb/tb_mxc_ripple_adder.sv
module tb_mxc_ripple_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk;
  logic rst_n;

  logic [W-1:0] a16, b16;
  logic         cin16;
  logic [W:0]   res16;

  logic [0:0]   a1, b1;
  logic         cin1;
  logic [1:0]   res1;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  mxc_ripple_adder #(.WIDTH(W)) dut (
    .op_a(a16), .op_b(b16), .carry_in(cin16), .result(res16)
  );

  mxc_ripple_adder #(.WIDTH(1)) dut1 (
    .op_a(a1), .op_b(b1), .carry_in(cin1), .result(res1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W:0] ref_sum(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic c);
    logic [W:0] t;
    t = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    return t;
  endfunction

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply16(input logic [W-1:0] x, input logic [W-1:0] y, input logic c,
                         input string req);
    @(posedge clk);
    a16 = x; b16 = y; cin16 = c;
    @(negedge clk);
    check(req, res16, ref_sum(x, y, c));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG_CYCLES) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    a16 = '0; b16 = '0; cin16 = 1'b0;
    a1 = '0; b1 = '0; cin1 = 1'b0;
    void'($urandom(32'd2024));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // R8: zero inputs give zero result with no clocked state involved
    @(negedge clk);
    check("R8 zero inputs", res16, '0);

    // R1 R2: every combination on the one-bit instance
    for (int v = 0; v < 8; v++) begin
      @(posedge clk);
      a1 = v[0]; b1 = v[1]; cin1 = v[2];
      @(negedge clk);
      check("R1 R2 cell truth", {{(W-1){1'b0}}, res1},
            {{(W-1){1'b0}}, 2'(v[0]) + 2'(v[1]) + 2'(v[2])});
    end

    // R7: single cell with all inputs high
    @(posedge clk);
    a1 = 1'b1; b1 = 1'b1; cin1 = 1'b1;
    @(negedge clk);
    check("R7 one-bit 1+1+1", {{(W-1){1'b0}}, res1}, 17'h3);

    // R6: bit pairs (0,1),(1,0),(0,1) give sum 7
    apply16(16'h0002, 16'h0005, 1'b0, "R6 worked example");
    check("R6 value", res16, 17'h00007);

    // R5: carry through the whole chain
    apply16(16'hFFFF, 16'h0000, 1'b1, "R5 full ripple");
    check("R5 value", res16, 17'h10000);

    // R3: top bit is the final carry
    apply16(16'hFFFF, 16'hFFFF, 1'b1, "R3 all ones with carry");
    check("R3 value", res16, 17'h1FFFF);
    apply16(16'hFFFF, 16'hFFFF, 1'b0, "R3 all ones");
    apply16(16'h0000, 16'h0000, 1'b1, "R4 carry only");
    apply16(16'hAAAA, 16'h5555, 1'b0, "R4 alternating");
    apply16(16'hAAAA, 16'h5555, 1'b1, "R5 alternating carry");
    apply16(16'hAAAA, 16'hAAAA, 1'b0, "R2 agreeing bits");
    apply16(16'h8000, 16'h8000, 1'b0, "R3 top bit carry");

    // R4: seeded random operands
    for (int i = 0; i < 300; i++) begin
      apply16(W'($urandom), W'($urandom), 1'($urandom), "R4 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule